// File: doc/BRIEF.md
# Conference Mixer with Output Gain

The block forms one mixed output sample per half-channel per frame for a set of eight half-channels that carry 16-bit signed linear PCM. Every channel holds a small configuration: a conference mode that says how many other channels are mixed in, up to three source channel numbers, and a two-bit output gain code. For each channel the mixer always starts from the channel's own sample. It adds the selected sources, scales the total by the coded gain and clips the result to the signed 16-bit range.

Samples enter through a valid/ready stream that writes the per-frame sample store, one channel number and one sample per transfer. A one-cycle frame strobe starts a pass over channels 0 to 7 in order. While a pass runs, the store is frozen: the input stream is back-pressured, so every channel of the pass reads the same set of samples and the results do not depend on the processing order. Results leave through a valid/ready stream tagged with the channel number. A stalled consumer holds the pass, and a done pulse marks the transfer of channel 7. Channels 0 to 3 are normally used as decode channels and 4 to 7 as encode channels. The mixer treats all eight alike.

Top module: `conf_mixer`

## Requirements
- R1: After reset every channel has mode code 00 and gain code 00, and no output is valid. With that configuration each output sample equals the channel's own stored sample.
- R2: Mode code 00 mixes nothing extra. Code 01 adds source A, code 10 adds sources A and B, and code 11 adds sources A, B and C, always on top of the channel's own sample.
- R3: Gain code 00 leaves the sum unchanged (0 dB). Code 01 doubles it (+6 dB). Code 11 is an arithmetic right shift by one (-6 dB), and code 10 is an arithmetic right shift by two (-12 dB).
- R4: The sum is formed without loss in an 18-bit accumulator and scaled. It is then saturated to [-32768, 32767], and the sign of the result follows the sign of the sum.
- R5: A configuration write selects a channel and either the control byte or the source byte. Control byte: bits [1:0] mode, bits [3:2] gain, bits [7:4] source A. Source byte: bits [3:0] source B, bits [7:4] source C. Within a source field only bits [2:0] name the channel, and bit 3 is ignored.
- R6: A frame strobe while idle starts a pass that outputs channels 0 through 7 exactly once each, in increasing order.
- R7: While out_valid is high and out_ready is low, out_valid, out_chan and out_sample hold their values.
- R8: frame_done is high exactly in the cycle in which channel 7 is transferred on the output stream.
- R9: During a pass, in_ready is low, an input sample offered with in_valid is not stored, and a further frame strobe is ignored. After the pass no extra output appears.
- R10: Source fields beyond those selected by the mode have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_chan | input | 3 | Channel whose configuration is written |
| cfg_hi | input | 1 | 1 selects the control byte, 0 the source byte |
| cfg_data | input | 8 | Configuration byte |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Input sample accepted (low during a pass) |
| in_chan | input | 3 | Channel of the input sample |
| in_sample | input | 16 | Signed linear input sample |
| frame_strobe | input | 1 | Starts a pass when idle |
| out_valid | output | 1 | Mixed sample available |
| out_ready | input | 1 | Consumer accepts the mixed sample |
| out_chan | output | 3 | Channel of the mixed sample |
| out_sample | output | 16 | Signed mixed, scaled and saturated sample |
| frame_done | output | 1 | Pulse on transfer of channel 7 |

## Verification
On every cycle the assertions check the following:
- output values are held while stalled;
- each accepted channel is followed by the next;
- a done pulse is followed only by channel 0 or by silence;
- an idle configuration passes the own sample through unchanged;
- the sign is kept through scaling and saturation;
- configuration and sample stores change only when written.

Only the bench's scenarios can show the arithmetic values. These cover the mode codes with junk in unused fields, the four gain codes on negative samples, saturation at both rails, and the exact -131072 corner. The scenarios also show that a write or strobe offered during a pass is lost rather than merely delayed.

// File: rtl/conf_mixer_pkg.sv
package conf_mixer_pkg;
  localparam int NSRC = 3;

  typedef enum logic [1:0] {
    MODE_SOLO  = 2'b00,
    MODE_ONE   = 2'b01,
    MODE_TWO   = 2'b10,
    MODE_THREE = 2'b11
  } mix_mode_e;

  typedef enum logic [1:0] {
    GAIN_0DB  = 2'b00,
    GAIN_P6DB = 2'b01,
    GAIN_M12  = 2'b10,
    GAIN_M6DB = 2'b11
  } gain_e;

  typedef struct packed {
    gain_e                 gain;
    mix_mode_e             mode;
    logic [NSRC-1:0][3:0]  src;
  } chan_cfg_t;
endpackage

// File: rtl/conf_mixer_cfg.sv
module conf_mixer_cfg
  import conf_mixer_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [$clog2(NCH)-1:0]     chan,
  input  logic                       hi_sel,
  input  logic [7:0]                 data,
  input  logic [$clog2(NCH)-1:0]     rd_chan,
  output chan_cfg_t                  rd_cfg
);
  localparam int CW = $clog2(NCH);

  logic [7:0] hi_q [NCH];
  logic [7:0] lo_q [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q[g] <= '0;
        lo_q[g] <= '0;
      end else if (we && chan == CW'(g)) begin
        if (hi_sel) hi_q[g] <= data;
        else        lo_q[g] <= data;
      end
    end

    // R5: a byte only changes when its own channel and half are written
    p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && chan == CW'(g)) |=> $stable(hi_q[g]) && $stable(lo_q[g]));
  end

  logic [7:0] hi_b, lo_b;
  assign hi_b = hi_q[rd_chan];
  assign lo_b = lo_q[rd_chan];

  always_comb begin
    rd_cfg.mode   = mix_mode_e'(hi_b[1:0]);
    rd_cfg.gain   = gain_e'(hi_b[3:2]);
    rd_cfg.src[0] = hi_b[7:4];
    rd_cfg.src[1] = lo_b[3:0];
    rd_cfg.src[2] = lo_b[7:4];
  end
endmodule

// File: rtl/conf_mixer_mem.sv
module conf_mixer_mem #(
  parameter int NCH = 8,
  parameter int SW  = 16,
  parameter int NRD = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [$clog2(NCH)-1:0]            wchan,
  input  logic [SW-1:0]                     wdata,
  input  logic [NRD-1:0][$clog2(NCH)-1:0]   raddr,
  output logic [NRD-1:0][SW-1:0]            rdata
);
  localparam int CW = $clog2(NCH);

  logic [SW-1:0] mem_q [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        mem_q[g] <= '0;
      else if (we && wchan == CW'(g))    mem_q[g] <= wdata;
    end

    // R9: a stored sample changes only through an accepted write
    p_mem_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && wchan == CW'(g)) |=> $stable(mem_q[g]));
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata[r] = mem_q[raddr[r]];
  end
endmodule

// File: rtl/conf_mixer_core.sv
module conf_mixer_core
  import conf_mixer_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SW-1:0]              own,
  input  logic [NSRC-1:0][SW-1:0]    srcs,
  input  mix_mode_e                  mode,
  input  gain_e                      gain,
  output logic [SW-1:0]              result
);
  localparam int AW = SW + 2;
  localparam int GW = AW + 1;
  localparam logic signed [GW-1:0] SAT_HI = GW'((64'sd1 <<< (SW-1)) - 64'sd1);
  localparam logic signed [GW-1:0] SAT_LO = -SAT_HI - GW'(1);

  function automatic logic signed [AW-1:0] sext(input logic [SW-1:0] v);
    return {{(AW-SW){v[SW-1]}}, v};
  endfunction

  logic signed [AW-1:0] acc;
  logic signed [GW-1:0] scaled;
  int unsigned          nsel;

  always_comb begin
    nsel = 32'(mode);
    acc  = sext(own);
    for (int i = 0; i < NSRC; i++) begin
      if (32'(i) < nsel) acc = acc + sext(srcs[i]);
    end
    scaled = GW'(acc);
    case (gain)
      GAIN_P6DB: scaled = scaled <<< 1;
      GAIN_M6DB: scaled = scaled >>> 1;
      GAIN_M12:  scaled = scaled >>> 2;
      default:   scaled = scaled;
    endcase
    if (scaled > SAT_HI)      result = SAT_HI[SW-1:0];
    else if (scaled < SAT_LO) result = SAT_LO[SW-1:0];
    else                      result = scaled[SW-1:0];
  end

  // R1: solo mode at unity gain passes the own sample through
  p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SOLO && gain == GAIN_0DB) |-> result == own);
  // R4: negative sums never come out positive after scaling and clipping
  p_sign_neg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc[AW-1] |-> result[SW-1]);
  // R4: non-negative sums never come out negative
  p_sign_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !acc[AW-1] |-> !result[SW-1]);
endmodule

// File: rtl/conf_mixer.sv
module conf_mixer
  import conf_mixer_pkg::*;
#(
  parameter int NCH = 8,
  parameter int SW  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [$clog2(NCH)-1:0]  cfg_chan,
  input  logic                    cfg_hi,
  input  logic [7:0]              cfg_data,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [$clog2(NCH)-1:0]  in_chan,
  input  logic [SW-1:0]           in_sample,
  input  logic                    frame_strobe,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [$clog2(NCH)-1:0]  out_chan,
  output logic [SW-1:0]           out_sample,
  output logic                    frame_done
);
  localparam int CW   = $clog2(NCH);
  localparam int NRD  = NSRC + 1;
  localparam logic [CW-1:0] LAST = CW'(NCH - 1);

  logic                       busy;
  logic [CW-1:0]              ch;
  logic                       adv;
  chan_cfg_t                  cur_cfg;
  logic [NRD-1:0][CW-1:0]     raddr;
  logic [NRD-1:0][SW-1:0]     rdata;
  logic [NSRC-1:0][SW-1:0]    srcs;
  logic [SW-1:0]              mixed;

  assign in_ready = !busy;
  assign adv      = busy && (!out_valid || out_ready);

  conf_mixer_cfg #(.NCH(NCH)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .chan(cfg_chan), .hi_sel(cfg_hi),
    .data(cfg_data), .rd_chan(ch), .rd_cfg(cur_cfg)
  );

  assign raddr[0] = ch;
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign raddr[g+1] = cur_cfg.src[g][CW-1:0];
    assign srcs[g]    = rdata[g+1];
  end

  conf_mixer_mem #(.NCH(NCH), .SW(SW), .NRD(NRD)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(in_valid && in_ready), .wchan(in_chan),
    .wdata(in_sample), .raddr(raddr), .rdata(rdata)
  );

  conf_mixer_core #(.SW(SW)) u_core (
    .clk(clk), .rst_n(rst_n), .own(rdata[0]), .srcs(srcs),
    .mode(cur_cfg.mode), .gain(cur_cfg.gain), .result(mixed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ch   <= '0;
    end else if (!busy && frame_strobe) begin
      busy <= 1'b1;
      ch   <= '0;
    end else if (adv) begin
      ch <= ch + CW'(1);
      if (ch == LAST) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_chan   <= '0;
      out_sample <= '0;
    end else if (adv) begin
      out_valid  <= 1'b1;
      out_chan   <= ch;
      out_sample <= mixed;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign frame_done = out_valid && out_ready && (out_chan == LAST);

  // R7: a stalled result is held unchanged
  p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_chan) && $stable(out_sample));
  // R6: after a channel other than the last is taken, the next one follows
  p_chan_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_chan != LAST) |=>
      out_valid && out_chan == $past(out_chan) + CW'(1));
  // R8: a done pulse is followed by silence or the start of the next pass
  p_done_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (!out_valid || out_chan == '0));
endmodule

// File: tb/conf_mixer_test.sv
module conf_mixer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_hi = 1'b0;
  logic [2:0] cfg_chan = '0;
  logic [7:0] cfg_data = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] in_chan = '0;
  logic [15:0] in_sample = '0;
  logic frame_strobe = 1'b0;
  logic out_valid, frame_done;
  logic out_ready = 1'b1;
  logic [2:0] out_chan;
  logic [15:0] out_sample;

  always #5 clk = ~clk;

  conf_mixer uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_hi(cfg_hi),
    .cfg_data(cfg_data), .in_valid(in_valid), .in_ready(in_ready), .in_chan(in_chan),
    .in_sample(in_sample), .frame_strobe(frame_strobe), .out_valid(out_valid),
    .out_ready(out_ready), .out_chan(out_chan), .out_sample(out_sample),
    .frame_done(frame_done)
  );

  typedef struct { int ch; int val; string tag; } exp_t;
  exp_t sb[$];

  int checks = 0, failures = 0;
  bit finished = 0;
  bit bp = 0;
  int cyc = 0;
  logic [7:0] m_hi [8];
  logic [7:0] m_lo [8];
  int smp [8];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model(input int c);
    int mode, gain, s, srcn[3];
    mode = int'(m_hi[c][1:0]);
    gain = int'(m_hi[c][3:2]);
    srcn[0] = int'(m_hi[c][6:4]);
    srcn[1] = int'(m_lo[c][2:0]);
    srcn[2] = int'(m_lo[c][6:4]);
    s = smp[c];
    for (int i = 0; i < mode; i++) s += smp[srcn[i]];
    case (gain)
      1: s = s * 2;
      3: s = s >>> 1;
      2: s = s >>> 2;
      default: ;
    endcase
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  always @(posedge clk) begin
    #1;
    cyc++;
    out_ready = bp ? (cyc % 3 != 0) : 1'b1;
  end

  // Monitor: pops expected items as transfers happen
  bit stalled = 0;
  logic [2:0] st_chan;
  logic [15:0] st_smp;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stalled)
        check(out_valid && out_chan == st_chan && out_sample == st_smp,
              "R7 stall hold", int'(out_sample), int'(st_smp));
      stalled = out_valid && !out_ready;
      st_chan = out_chan;
      st_smp  = out_sample;
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(0, "R9 unexpected output", int'(out_chan), -1);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(int'(out_chan) == e.ch, {e.tag, " R6 chan"}, int'(out_chan), e.ch);
          check(int'($signed(out_sample)) == e.val, e.tag, int'($signed(out_sample)), e.val);
          check(frame_done == (e.ch == 7), "R8 done", int'(frame_done), int'(e.ch == 7));
        end
      end else if (frame_done) begin
        check(0, "R8 done without transfer", 1, 0);
      end
    end
  end

  task automatic put_cfg(input int c, input logic [7:0] hi, input logic [7:0] lo);
    @(posedge clk); #1;
    cfg_we = 1; cfg_chan = 3'(c); cfg_hi = 1; cfg_data = hi;
    @(posedge clk); #1;
    cfg_hi = 0; cfg_data = lo;
    @(posedge clk); #1;
    cfg_we = 0;
    m_hi[c] = hi; m_lo[c] = lo;
  endtask

  task automatic put_smp(input int c, input int v);
    @(posedge clk); #1;
    in_valid = 1; in_chan = 3'(c); in_sample = 16'(v);
    @(posedge clk); #1;
    in_valid = 0;
    smp[c] = v;
  endtask

  task automatic run_frame(input string tag, input bit poke_busy);
    for (int c = 0; c < 8; c++) begin
      exp_t e;
      e.ch = c; e.val = model(c); e.tag = tag;
      sb.push_back(e);
    end
    @(posedge clk); #1;
    frame_strobe = 1;
    @(posedge clk); #1;
    frame_strobe = 0;
    if (poke_busy) begin
      @(posedge clk); #1;
      frame_strobe = 1; in_valid = 1; in_chan = 3'd0; in_sample = 16'h1234;
      @(negedge clk);
      check(in_ready == 0, "R9 in_ready low in pass", int'(in_ready), 0);
      @(posedge clk); #1;
      frame_strobe = 0; in_valid = 0;
    end
    while (sb.size() != 0) @(posedge clk);
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(out_valid == 0, {tag, " R9 no extra output"}, int'(out_valid), 0);
    check(in_ready == 1, {tag, " R9 ready when idle"}, int'(in_ready), 1);
  endtask

  initial begin
    for (int c = 0; c < 8; c++) begin m_hi[c] = 0; m_lo[c] = 0; smp[c] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(out_valid == 0 && frame_done == 0, "R1 reset outputs", int'(out_valid), 0);
    check(in_ready == 1, "R1 reset in_ready", int'(in_ready), 1);

    // R1: reset configuration passes own samples through
    for (int c = 0; c < 8; c++) put_smp(c, (c + 1) * 1000 - 4500);
    run_frame("R1 default passthrough", 0);

    // R2 / R5 / R10: modes with junk in unused source fields and bit 3 set
    put_cfg(0, 8'h21, 8'hFF);   // mode 01, src A=2, B/C unused junk
    put_cfg(1, 8'hB2, 8'h7C);   // mode 10, src A=3 (bit3 set), B=4 (bit3 set), C junk
    put_cfg(2, 8'h53, 8'h76);   // mode 11, A=5, B=6, C=7
    put_cfg(3, 8'h70, 8'h65);   // mode 00 with sources present: ignored
    put_cfg(7, 8'h03, 8'h00);   // mode 11 all sources channel 0
    run_frame("R2 R5 R10 modes", 0);

    // R3: all gain codes on negative and odd values
    for (int c = 0; c < 8; c++) put_smp(c, -(c * 777) - 3);
    put_cfg(0, 8'h00, 8'h00);
    put_cfg(1, 8'h04, 8'h00);   // +6 dB
    put_cfg(2, 8'h08, 8'h00);   // -12 dB
    put_cfg(3, 8'h0C, 8'h00);   // -6 dB
    put_cfg(4, 8'h0D, 8'h00);   // -6 dB, mode 01 src 0
    put_cfg(5, 8'h19, 8'h00);   // -12 dB, mode 01 src 1
    put_cfg(6, 8'h0C, 8'h00);
    put_cfg(7, 8'h08, 8'h00);
    run_frame("R3 gains", 0);

    // R4: saturation and the exact lower corner, with back-pressure (R7)
    put_smp(0, 30000); put_smp(1, 30000); put_smp(2, -30000); put_smp(3, -32768);
    put_smp(4, 20000); put_smp(5, -32768); put_smp(6, 10000); put_smp(7, -20000);
    for (int c = 0; c < 4; c++) put_cfg(c, 8'h08, 8'h00);
    put_cfg(4, 8'h03, 8'h01);   // 0+1+0 own 20000 -> clip high
    put_cfg(5, 8'h3B, 8'h33);   // -4*32768 at -12 dB -> -32768 exact
    put_cfg(6, 8'h05, 8'h00);   // +6 dB of 40000 -> clip high
    put_cfg(7, 8'h04, 8'h00);   // +6 dB of -20000 -> clip low
    bp = 1;
    run_frame("R4 R7 saturate", 0);

    // R9: strobe and sample write offered during a pass are dropped
    run_frame("R9 busy poke", 1);
    bp = 0;
    run_frame("R9 store unchanged", 0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule